// File: doc/BRIEF.md
# Programmable Cipher Shift Register

This block is a 24-bit linear feedback shift register for generating cipher keystream. Four runtime masks set its behaviour. The feedback mask marks the cells whose XOR is fed back. The output mask marks the cells whose XOR forms the keystream bit. The vote mask marks the cells that take part in a bitwise majority vote. The inversion mask marks which of those voting cells are complemented before the vote.

On every shift, the contents move one place from the most significant end toward the least significant end. The feedback value always enters the most significant cell. An external serial bit, which a gate input can force to zero, is combined at one end of the register. A select input chooses that end: at the left end it is XORed with the feedback, and at the right end it is XORed into the rightmost cell after the move.

A simple register port writes and reads back the shift register and all four masks. A hardware reset clears everything. A software clear or a local clear empties the shift register only.

Top module: `keystream_lfsr`

## Requirements
- R1: After a hardware reset (`rst` high at a clock edge) the shift register and all four masks read 0, and `key_out` and `maj_out` are 0.
- R2: On a shift, bit i of the new state equals bit i+1 of the old state, for i from 1 to 22.
- R3: With `at_left`=1, a shift loads bit 23 with the XOR of the feedback value and the gated input, and loads bit 0 with the old bit 1.
- R4: With `at_left`=0, a shift loads bit 23 with the feedback value alone, and loads bit 0 with the old bit 1 XOR the gated input.
- R5: While `gate`=1 the gated input is 0 whatever `din` is, so new data comes from the feedback alone.
- R6: The feedback value is the XOR of all state bits whose feedback-mask bit is 1.
- R7: `key_out` is, combinationally, the XOR of all state bits whose output-mask bit is 1.
- R8: `maj_out` is 1 exactly when strictly more than half of the vote-selected bits are 1, where each selected bit is first XORed with its inversion-mask bit.
- R9: With no bit selected, `maj_out` is 0. A tie, where exactly half of the selected bits are 1, also gives 0.
- R10: A pulse on `soft_clr` or on `local_clr` sets the shift register to 0 at the next edge and leaves all masks unchanged.
- R11: A write to the shift register in the same cycle as `shift_en` stores the written value, and the shift is discarded.
- R12: Register select codes are 0 for the state, 1 for the feedback mask, 2 for the output mask, 3 for the vote mask and 4 for the inversion mask. A write stores `wr_data` at the next edge and `rd_data` returns the selected register combinationally. Codes 5 to 7 read as 0, and a write to them changes no register.
- R13: When `shift_en`, the state write and both clears are inactive, the shift register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset, clears everything |
| soft_clr | input | 1 | Software clear of the shift register |
| local_clr | input | 1 | Block-local clear of the shift register |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for writes |
| wr_data | input | 24 | Write data |
| rd_sel | input | 3 | Register select for reads |
| rd_data | output | 24 | Read data of the selected register |
| shift_en | input | 1 | Perform one shift this cycle |
| din | input | 1 | Serial input bit |
| at_left | input | 1 | 1: input at the left end, 0: input at the right end |
| gate | input | 1 | 1: force the serial input to zero |
| key_out | output | 1 | Keystream bit from the output taps |
| maj_out | output | 1 | Bitwise majority result |

## Verification
The clocked properties assume that `rst` is asserted at the first edges. They also assume that every control input is a clean 0 or 1 at each edge, with writes, shifts and clears able to coincide freely. The bench drives all inputs on the falling edge and holds them through the next rising edge. It releases reset before any write, and it deliberately overlaps a state write with a shift to cover the priority rule. The majority check with nothing selected assumes only that the vote mask is known, which the hardware reset guarantees.

// File: rtl/cfsr_pkg.sv
package cfsr_pkg;
    localparam int CFSR_W = 24;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        SEL_STATE = 3'd0,
        SEL_FBK   = 3'd1,
        SEL_FFW   = 3'd2,
        SEL_VOTE  = 3'd3,
        SEL_INV   = 3'd4
    } reg_sel_e;

    typedef struct packed {
        logic shift;
        logic din;
        logic at_left;
        logic gate;
    } shift_ctl_t;
endpackage

// File: rtl/cfsr_masks.sv
module cfsr_masks #(
    parameter int W = cfsr_pkg::CFSR_W,
    parameter int AW = cfsr_pkg::ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_sel,
    input  logic [W-1:0]  wr_data,
    output logic [W-1:0]  fbk_m,
    output logic [W-1:0]  ffw_m,
    output logic [W-1:0]  vote_m,
    output logic [W-1:0]  inv_m
);
    import cfsr_pkg::*;

    always_ff @(posedge clk) begin
        if (rst) begin
            fbk_m  <= '0;
            ffw_m  <= '0;
            vote_m <= '0;
            inv_m  <= '0;
        end else if (wr_en) begin
            case (wr_sel)
                SEL_FBK:  fbk_m  <= wr_data;
                SEL_FFW:  ffw_m  <= wr_data;
                SEL_VOTE: vote_m <= wr_data;
                SEL_INV:  inv_m  <= wr_data;
                default:  ;
            endcase
        end
    end

    // R12: masks move only on a write strobe
    a_r12_masks_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable({fbk_m, ffw_m, vote_m, inv_m}));
endmodule

// File: rtl/cfsr_shift_core.sv
module cfsr_shift_core #(
    parameter int W = cfsr_pkg::CFSR_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr,
    input  logic                 wr_state,
    input  logic [W-1:0]         wr_data,
    input  cfsr_pkg::shift_ctl_t ctl,
    input  logic [W-1:0]         fbk_m,
    output logic [W-1:0]         state
);
    logic         fb_bit;
    logic         gated_in;
    logic [W-1:0] nxt;

    assign fb_bit   = ^(state & fbk_m);
    assign gated_in = ctl.din & ~ctl.gate;

    always_comb begin
        nxt = {fb_bit ^ (ctl.at_left & gated_in), state[W-1:1]};
        if (!ctl.at_left) begin
            nxt[0] = state[1] ^ gated_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            state <= '0;
        end else if (wr_state) begin
            state <= wr_data;
        end else if (ctl.shift) begin
            state <= nxt;
        end
    end

    // R2: interior cells move one place toward the right end
    a_r2_moves_right: assert property (@(posedge clk) disable iff (rst)
        (ctl.shift && !wr_state && !clr) |=> state[W-2:1] == $past(state[W-1:2]));

    // R10: a clear empties the register
    a_r10_clear_empties: assert property (@(posedge clk) disable iff (rst)
        clr |=> state == '0);

    // R11: a state write beats a shift
    a_r11_write_wins: assert property (@(posedge clk) disable iff (rst)
        (wr_state && !clr) |=> state == $past(wr_data));

    // R13: idle cycles hold the contents
    a_r13_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!ctl.shift && !wr_state && !clr) |=> $stable(state));
endmodule

// File: rtl/cfsr_majority.sv
module cfsr_majority #(
    parameter int W = cfsr_pkg::CFSR_W
) (
    input  logic [W-1:0] state,
    input  logic [W-1:0] vote_m,
    input  logic [W-1:0] inv_m,
    output logic         maj
);
    localparam int CW = $clog2(W + 1) + 1;

    logic [W-1:0]  votes;
    logic [CW-1:0] ones;
    logic [CW-1:0] total;

    assign votes = (state ^ inv_m) & vote_m;

    always_comb begin
        ones  = '0;
        total = '0;
        for (int i = 0; i < W; i++) begin
            ones  = ones + CW'(votes[i]);
            total = total + CW'(vote_m[i]);
        end
    end

    assign maj = (ones << 1) > total;

    // R9: nothing selected gives a zero vote
    always_comb begin
        if (vote_m == '0) begin
            a_r9_empty_vote: assert (!maj);
        end
    end
endmodule

// File: rtl/keystream_lfsr.sv
module keystream_lfsr #(
    parameter int W = cfsr_pkg::CFSR_W,
    parameter int AW = cfsr_pkg::ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          soft_clr,
    input  logic          local_clr,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_sel,
    input  logic [W-1:0]  wr_data,
    input  logic [AW-1:0] rd_sel,
    output logic [W-1:0]  rd_data,
    input  logic          shift_en,
    input  logic          din,
    input  logic          at_left,
    input  logic          gate,
    output logic          key_out,
    output logic          maj_out
);
    import cfsr_pkg::*;

    logic [W-1:0] fbk_m, ffw_m, vote_m, inv_m, state;
    logic         clr, wr_state;
    shift_ctl_t   ctl;

    assign clr      = soft_clr | local_clr;
    assign wr_state = wr_en && (wr_sel == SEL_STATE);
    assign ctl      = '{shift: shift_en, din: din, at_left: at_left, gate: gate};

    cfsr_masks #(.W(W), .AW(AW)) masks_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .fbk_m(fbk_m), .ffw_m(ffw_m), .vote_m(vote_m), .inv_m(inv_m)
    );

    cfsr_shift_core #(.W(W)) core_i (
        .clk(clk), .rst(rst), .clr(clr), .wr_state(wr_state), .wr_data(wr_data),
        .ctl(ctl), .fbk_m(fbk_m), .state(state)
    );

    cfsr_majority #(.W(W)) vote_i (
        .state(state), .vote_m(vote_m), .inv_m(inv_m), .maj(maj_out)
    );

    assign key_out = ^(state & ffw_m);

    always_comb begin
        case (rd_sel)
            SEL_STATE: rd_data = state;
            SEL_FBK:   rd_data = fbk_m;
            SEL_FFW:   rd_data = ffw_m;
            SEL_VOTE:  rd_data = vote_m;
            SEL_INV:   rd_data = inv_m;
            default:   rd_data = '0;
        endcase
    end

    // R1: the cycle after a hardware reset everything is empty
    a_r1_reset_empty: assert property (@(posedge clk)
        rst |=> (state == '0 && fbk_m == '0 && vote_m == '0 && !key_out));
endmodule

// File: tb/keystream_lfsr_tb_top.sv
module keystream_lfsr_tb_top;
    localparam int W = 24;

    logic         clk = 1'b0;
    logic         rst, soft_clr, local_clr, wr_en, shift_en, din, at_left, gate;
    logic [2:0]   wr_sel, rd_sel;
    logic [W-1:0] wr_data, rd_data;
    logic         key_out, maj_out;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    keystream_lfsr dut_i (
        .clk(clk), .rst(rst), .soft_clr(soft_clr), .local_clr(local_clr),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
        .rd_data(rd_data), .shift_en(shift_en), .din(din), .at_left(at_left),
        .gate(gate), .key_out(key_out), .maj_out(maj_out)
    );

    typedef struct packed {
        logic [W-1:0] st;
        logic [W-1:0] fb;
        logic [W-1:0] ff;
        logic [W-1:0] vs;
        logic [W-1:0] iv;
        logic         di;
        logic         lf;
        logic         gt;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{24'hA5C3F1, 24'h800021, 24'h00F00F, 24'hFFFFFF, 24'h000000, 1'b1, 1'b1, 1'b0},
        '{24'h123456, 24'h400003, 24'h0F0F0F, 24'h0000FF, 24'h0000F0, 1'b1, 1'b0, 1'b0},
        '{24'hFFFFFF, 24'hFFFFFF, 24'h000001, 24'h000000, 24'h000000, 1'b1, 1'b1, 1'b1},
        '{24'h000001, 24'h000001, 24'h800000, 24'h000007, 24'h000002, 1'b0, 1'b0, 1'b0},
        '{24'h800000, 24'h800000, 24'h800001, 24'h800001, 24'h000001, 1'b1, 1'b0, 1'b1},
        '{24'h5A5A5A, 24'h0C0300, 24'hFFFFFF, 24'hAAAAAA, 24'hFFFFFF, 1'b0, 1'b1, 1'b0},
        '{24'h000002, 24'h000000, 24'h000002, 24'h000003, 24'h000000, 1'b1, 1'b0, 1'b0},
        '{24'hDEADBE, 24'hE10000, 24'h000C30, 24'hF0F0F0, 24'h0F0F0F, 1'b1, 1'b1, 1'b1}
    };

    function automatic logic par(input logic [W-1:0] v);
        logic p = 1'b0;
        for (int i = 0; i < W; i++) p ^= v[i];
        return p;
    endfunction

    function automatic logic [W-1:0] model_next(input logic [W-1:0] s, input logic [W-1:0] fb,
                                                input logic di, input logic lf, input logic gt);
        logic g = di & ~gt;
        logic f = par(s & fb);
        logic [W-1:0] n = s >> 1;
        n[W-1] = lf ? (f ^ g) : f;
        if (!lf) n[0] = s[1] ^ g;
        return n;
    endfunction

    function automatic logic model_maj(input logic [W-1:0] s, input logic [W-1:0] vs,
                                       input logic [W-1:0] iv);
        int c = 0;
        int n = 0;
        for (int i = 0; i < W; i++) begin
            if (vs[i]) begin
                n++;
                if (s[i] ^ iv[i]) c++;
            end
        end
        return (2 * c) > n;
    endfunction

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [2:0] a, input logic [W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_reg(input logic [2:0] a, output logic [W-1:0] d);
        rd_sel = a;
        #1;
        d = rd_data;
    endtask

    task automatic do_shift(input logic di, input logic lf, input logic gt);
        @(negedge clk);
        shift_en = 1'b1; din = di; at_left = lf; gate = gt;
        @(negedge clk);
        shift_en = 1'b0;
    endtask

    initial begin
        #1_000_000;
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [W-1:0] rv, exp_s;
        rst = 1'b1; soft_clr = 1'b0; local_clr = 1'b0; wr_en = 1'b0; wr_sel = '0;
        wr_data = '0; rd_sel = '0; shift_en = 1'b0; din = 1'b0; at_left = 1'b1; gate = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        for (int a = 0; a < 5; a++) begin
            read_reg(3'(a), rv);
            check("R1 reset register", rv, '0);
        end
        check("R1 key_out", {23'd0, key_out}, '0);
        check("R1 maj_out", {23'd0, maj_out}, '0);

        // Table walk: R2..R9, R12
        for (int k = 0; k < NV; k++) begin
            write_reg(3'd1, VECS[k].fb);
            write_reg(3'd2, VECS[k].ff);
            write_reg(3'd3, VECS[k].vs);
            write_reg(3'd4, VECS[k].iv);
            write_reg(3'd0, VECS[k].st);
            read_reg(3'd0, rv);
            check("R12 state readback", rv, VECS[k].st);
            read_reg(3'd3, rv);
            check("R12 vote mask readback", rv, VECS[k].vs);
            check("R7 key_out", {23'd0, key_out}, {23'd0, par(VECS[k].st & VECS[k].ff)});
            check("R8 maj_out", {23'd0, maj_out},
                  {23'd0, model_maj(VECS[k].st, VECS[k].vs, VECS[k].iv)});
            do_shift(VECS[k].di, VECS[k].lf, VECS[k].gt);
            exp_s = model_next(VECS[k].st, VECS[k].fb, VECS[k].di, VECS[k].lf, VECS[k].gt);
            read_reg(3'd0, rv);
            check(VECS[k].lf ? "R3 R5 R6 left shift" : "R4 R5 R6 right shift", rv, exp_s);
            check("R7 key_out after shift", {23'd0, key_out},
                  {23'd0, par(exp_s & VECS[k].ff)});
        end

        // R2: several shifts with feedback off move a marker bit right
        write_reg(3'd1, 24'h000000);
        write_reg(3'd0, 24'h800000);
        for (int j = 0; j < 5; j++) do_shift(1'b0, 1'b1, 1'b0);
        read_reg(3'd0, rv);
        check("R2 five shifts", rv, 24'h040000);

        // R5: gated input with zero feedback inserts nothing at either end
        do_shift(1'b1, 1'b1, 1'b1);
        do_shift(1'b1, 1'b0, 1'b1);
        read_reg(3'd0, rv);
        check("R5 gate blocks input", rv, 24'h010000);

        // R9: tie gives 0, single 1 of two selected
        write_reg(3'd3, 24'h000003);
        write_reg(3'd4, 24'h000000);
        write_reg(3'd0, 24'h000001);
        check("R9 tie", {23'd0, maj_out}, '0);
        write_reg(3'd3, 24'h000000);
        write_reg(3'd0, 24'hFFFFFF);
        check("R9 empty selection", {23'd0, maj_out}, '0);

        // R11: write and shift in the same cycle
        write_reg(3'd1, 24'hFFFFFF);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 3'd0; wr_data = 24'h3C3C3C;
        shift_en = 1'b1; din = 1'b1; at_left = 1'b1; gate = 1'b0;
        @(negedge clk);
        wr_en = 1'b0; shift_en = 1'b0;
        read_reg(3'd0, rv);
        check("R11 write beats shift", rv, 24'h3C3C3C);

        // R13: idle cycles hold
        repeat (4) @(negedge clk);
        read_reg(3'd0, rv);
        check("R13 idle hold", rv, 24'h3C3C3C);

        // R12: unused codes read 0 and ignore writes
        write_reg(3'd5, 24'h777777);
        write_reg(3'd7, 24'h555555);
        read_reg(3'd5, rv);
        check("R12 code 5 reads 0", rv, '0);
        read_reg(3'd0, rv);
        check("R12 state untouched", rv, 24'h3C3C3C);
        read_reg(3'd1, rv);
        check("R12 feedback mask untouched", rv, 24'hFFFFFF);

        // R10: software clear then local clear
        @(negedge clk); soft_clr = 1'b1;
        @(negedge clk); soft_clr = 1'b0;
        read_reg(3'd0, rv);
        check("R10 soft clear state", rv, '0);
        read_reg(3'd1, rv);
        check("R10 soft clear keeps mask", rv, 24'hFFFFFF);
        write_reg(3'd0, 24'h00ABCD);
        @(negedge clk); local_clr = 1'b1;
        @(negedge clk); local_clr = 1'b0;
        read_reg(3'd0, rv);
        check("R10 local clear state", rv, '0);
        read_reg(3'd3, rv);
        check("R10 local clear keeps mask", rv, 24'h000000);

        // R1: hardware reset clears masks too
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        read_reg(3'd1, rv);
        check("R1 reset clears mask", rv, '0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule